// File: doc/BRIEF.md
# Per-Cycle Current Peak Supervisor

This block watches the current-sense comparators of a resonant half-bridge controller and turns them into per-switching-cycle decisions. All comparator inputs are single bits from analog threshold detectors, and each pair arrives already split into an entry level and an exit level. The block brings these bits and the first primary gate output into the 40 MHz clock domain. At every falling edge of that gate it latches a set of decision flags: synchronous-rectifier gate shrink, synchronous-rectifier skip, slow and fast compensation cutback, and a non-ZVS cutback request.

Shrink and skip hold their state between their entry and exit levels, which gives them hysteresis. The two cutback levels and the overcurrent level on the integrated peak each have an alternate, higher comparator. That comparator takes over while the deep-below-resonance input is high. A separate path watches the overcurrent conditions continuously. It raises a latched fault once one of them has been present for the debounce window, and the fault stays set until the restart sequencer clears it. Reset and undervoltage lockout both force every output to its safe state.

Top module: `cyc_peak_supervisor`

## Requirements
- R1: During reset, and one clock after `uvlo` is sampled high, the outputs are in the safe state: `sr_shrink`=1, `sr_skip`=1, and `cb_slow`, `cb_fast`, `nzvs_req` and `ocp_fault` are all 0.
- R2: At a sample point, `sr_shrink` becomes 1 if `pk_below_shr` is 1. Otherwise it becomes 0 if `pk_above_shr_exit` is 1. Otherwise it keeps its value.
- R3: At a sample point, `sr_skip` becomes 1 if `pk_below_skp` is 1. Otherwise it becomes 0 if `pk_above_skp_exit` is 1. Otherwise it keeps its value.
- R4: At a sample point with deep-below-resonance off, `cb_slow` takes the value of `pk_ocl1_nrm` and `cb_fast` takes the value of `pk_ocl2_nrm`.
- R5: While `deep_br` is 1, the slow and fast cutback and the integrated overcurrent check use `pk_ocl1_hi`, `pk_ocl2_hi` and `pk_ocp1_hi` in place of their normal-level inputs.
- R6: At a sample point, `nzvs_req` becomes 1 exactly when `comp_hi` is 1 and `cs_pk_hi` is 0. It holds that value until the next sample point.
- R7: The flag outputs (`sr_shrink`, `sr_skip`, `cb_slow`, `cb_fast`, `nzvs_req`) change only at a falling edge of `gate1`. Comparator changes without such an edge have no effect.
- R8: `ocp_fault` rises only after the selected integrated overcurrent bit, `cs_over_pos` or `cs_over_neg` has stayed high for `DEB_CYC` (6) consecutive synchronized cycles. A shorter trip pulse leaves it low.
- R9: Once set, `ocp_fault` stays high until `fault_clr` or `uvlo` is sampled high.
- R10: A falling edge of `gate1`, driven between clock edges, shows up on the flag outputs after the third following rising clock edge. It does not show after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo | input | 1 | Undervoltage lockout active, forces the safe state |
| fault_clr | input | 1 | Clears the latched overcurrent fault (from the restart sequencer) |
| gate1 | input | 1 | First primary gate output; its falling edge is the sample point |
| deep_br | input | 1 | Deep-below-resonance mode, selects the higher limit comparators |
| pk_below_shr | input | 1 | Integrated peak below the shrink entry level (0.20 V equivalent) |
| pk_above_shr_exit | input | 1 | Integrated peak above the shrink exit level (0.25 V equivalent) |
| pk_below_skp | input | 1 | Integrated peak below the skip entry level (0.075 V equivalent) |
| pk_above_skp_exit | input | 1 | Integrated peak above the skip exit level (0.15 V equivalent) |
| pk_ocl1_nrm | input | 1 | Integrated peak above the first current limit, normal set |
| pk_ocl2_nrm | input | 1 | Integrated peak above the second current limit, normal set |
| pk_ocp1_nrm | input | 1 | Integrated peak above the overcurrent level, normal set |
| pk_ocl1_hi | input | 1 | Integrated peak above the first current limit, deep-below-resonance set |
| pk_ocl2_hi | input | 1 | Integrated peak above the second current limit, deep-below-resonance set |
| pk_ocp1_hi | input | 1 | Integrated peak above the overcurrent level, deep-below-resonance set |
| comp_hi | input | 1 | Loop compensation voltage above 3 V |
| cs_pk_hi | input | 1 | Sense peak above 0.3 V during the cycle |
| cs_over_pos | input | 1 | Instantaneous sense above +3.5 V |
| cs_over_neg | input | 1 | Instantaneous sense below -3.5 V |
| sr_shrink | output | 1 | Widen the synchronous-rectifier dead times |
| sr_skip | output | 1 | Disable the synchronous rectifiers |
| cb_slow | output | 1 | Slow compensation cutback request |
| cb_fast | output | 1 | Fast compensation cutback request |
| nzvs_req | output | 1 | Non-ZVS compensation cutback request |
| ocp_fault | output | 1 | Latched overcurrent fault |

## Verification
A falling edge of `gate1` reaches the flag outputs after three rising clock edges: two for the synchronizer and one for the flag register. The bench therefore samples on the falling clock edge after the second rising edge, where it expects the old flags, and again after the third, where it expects the new ones. A trip level driven high before rising edge p sets the fault at edge p+7. The bench holds each trip pulse for a measured number of cycles and looks at the fault ten cycles after the pulse ends, so pulses one cycle short of the window and pulses at the window length end up on opposite sides of the decision. Clear and lockout act one edge later, and the bench checks them two falling edges after it drives them.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef struct packed {
    logic shrink;
    logic skip;
    logic cb_slow;
    logic cb_fast;
    logic nzvs;
  } cyc_flags_t;

  // one hysteresis pair: below entry level / above exit level
  typedef struct packed {
    logic below_entry;
    logic above_exit;
  } hyst_pair_t;

  // one limit with its normal and deep-below-resonance comparator
  typedef struct packed {
    logic lvl_nrm;
    logic lvl_hi;
  } lim_pair_t;

  localparam cyc_flags_t FLAGS_SAFE = '{shrink: 1'b1, skip: 1'b1,
                                        cb_slow: 1'b0, cb_fast: 1'b0,
                                        nzvs: 1'b0};

  function automatic logic hyst_next(logic cur, hyst_pair_t p);
    if (p.below_entry)     return 1'b1;
    else if (p.above_exit) return 1'b0;
    else                   return cur;
  endfunction

  function automatic logic lim_pick(lim_pair_t p, logic use_hi);
    return use_hi ? p.lvl_hi : p.lvl_nrm;
  endfunction

endpackage

// File: rtl/cps_sync_bank.sv
module cps_sync_bank #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = din;
    end else begin : g_next
      always_comb stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/cps_cycle_flags.sv
module cps_cycle_flags
  import cps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uvlo,
  input  logic       sample_en,
  input  logic       deep_sel,
  input  hyst_pair_t shr_pair,
  input  hyst_pair_t skp_pair,
  input  lim_pair_t  ocl1_pair,
  input  lim_pair_t  ocl2_pair,
  input  logic       comp_hi,
  input  logic       cs_pk_hi,
  output cyc_flags_t flags_q
);

  cyc_flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (uvlo) begin
      flags_d = FLAGS_SAFE;
    end else if (sample_en) begin
      flags_d.shrink  = hyst_next(flags_q.shrink, shr_pair);
      flags_d.skip    = hyst_next(flags_q.skip, skp_pair);
      flags_d.cb_slow = lim_pick(ocl1_pair, deep_sel);
      flags_d.cb_fast = lim_pick(ocl2_pair, deep_sel);
      flags_d.nzvs    = comp_hi & ~cs_pk_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= FLAGS_SAFE;
    else        flags_q <= flags_d;
  end

endmodule

// File: rtl/cps_ocp_debounce.sv
module cps_ocp_debounce #(
  parameter int DEB_CYC = 6,
  parameter int N_SRC   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uvlo,
  input  logic             fault_clr,
  input  logic [N_SRC-1:0] trip_src,
  output logic             fault_q
);

  localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic          trip;
  logic          trip_done;
  logic [CW-1:0] run_q, run_d;
  logic          fault_d;

  assign trip      = |trip_src;
  assign trip_done = trip && (run_q == LAST);

  always_comb begin
    run_d = run_q;
    if (uvlo || !trip)   run_d = '0;
    else if (run_q != LAST) run_d = run_q + 1'b1;
  end

  always_comb begin
    fault_d = fault_q;
    if (uvlo || fault_clr) fault_d = 1'b0;
    else if (trip_done)    fault_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      fault_q <= fault_d;
    end
  end

endmodule

// File: rtl/cyc_peak_supervisor.sv
module cyc_peak_supervisor
  import cps_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYC     = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uvlo,
  input  logic fault_clr,
  input  logic gate1,
  input  logic deep_br,
  input  logic pk_below_shr,
  input  logic pk_above_shr_exit,
  input  logic pk_below_skp,
  input  logic pk_above_skp_exit,
  input  logic pk_ocl1_nrm,
  input  logic pk_ocl2_nrm,
  input  logic pk_ocp1_nrm,
  input  logic pk_ocl1_hi,
  input  logic pk_ocl2_hi,
  input  logic pk_ocp1_hi,
  input  logic comp_hi,
  input  logic cs_pk_hi,
  input  logic cs_over_pos,
  input  logic cs_over_neg,
  output logic sr_shrink,
  output logic sr_skip,
  output logic cb_slow,
  output logic cb_fast,
  output logic nzvs_req,
  output logic ocp_fault
);

  localparam int NSYNC = 16;
  localparam int N_TRIP = 3;

  logic [NSYNC-1:0] raw_vec, syn_vec;
  logic             gate_s, deep_s;
  hyst_pair_t       shr_s, skp_s;
  lim_pair_t        ocl1_s, ocl2_s, ocp1_s;
  logic             comp_hi_s, cs_pk_hi_s, over_pos_s, over_neg_s;
  logic             gate_prev_q;
  logic             gate_fall;
  logic [N_TRIP-1:0] trip_vec;
  cyc_flags_t       flags;

  assign raw_vec = {gate1, deep_br,
                    pk_below_shr, pk_above_shr_exit,
                    pk_below_skp, pk_above_skp_exit,
                    pk_ocl1_nrm, pk_ocl1_hi,
                    pk_ocl2_nrm, pk_ocl2_hi,
                    pk_ocp1_nrm, pk_ocp1_hi,
                    comp_hi, cs_pk_hi, cs_over_pos, cs_over_neg};

  cps_sync_bank #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw_vec),
    .dout (syn_vec)
  );

  assign {gate_s, deep_s, shr_s, skp_s, ocl1_s, ocl2_s, ocp1_s,
          comp_hi_s, cs_pk_hi_s, over_pos_s, over_neg_s} = syn_vec;

  // falling-edge detect on the synchronized gate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_prev_q <= 1'b0;
    else        gate_prev_q <= gate_s;
  end

  assign gate_fall = gate_prev_q & ~gate_s;

  cps_cycle_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .uvlo     (uvlo),
    .sample_en(gate_fall),
    .deep_sel (deep_s),
    .shr_pair (shr_s),
    .skp_pair (skp_s),
    .ocl1_pair(ocl1_s),
    .ocl2_pair(ocl2_s),
    .comp_hi  (comp_hi_s),
    .cs_pk_hi (cs_pk_hi_s),
    .flags_q  (flags)
  );

  assign trip_vec = {lim_pick(ocp1_s, deep_s), over_pos_s, over_neg_s};

  cps_ocp_debounce #(.DEB_CYC(DEB_CYC), .N_SRC(N_TRIP)) u_deb (
    .clk      (clk),
    .rst_n    (rst_n),
    .uvlo     (uvlo),
    .fault_clr(fault_clr),
    .trip_src (trip_vec),
    .fault_q  (ocp_fault)
  );

  assign sr_shrink = flags.shrink;
  assign sr_skip   = flags.skip;
  assign cb_slow   = flags.cb_slow;
  assign cb_fast   = flags.cb_fast;
  assign nzvs_req  = flags.nzvs;

endmodule

// File: rtl/cps_supervisor_chk.sv
module cps_supervisor_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYC     = 6
) (
  input logic clk,
  input logic rst_n,
  input logic uvlo,
  input logic fault_clr,
  input logic gate1,
  input logic deep_br,
  input logic pk_ocp1_nrm,
  input logic pk_ocp1_hi,
  input logic cs_over_pos,
  input logic cs_over_neg,
  input logic sr_shrink,
  input logic sr_skip,
  input logic cb_slow,
  input logic cb_fast,
  input logic nzvs_req,
  input logic ocp_fault
);

  localparam int RW = $clog2(DEB_CYC + 1);
  localparam logic [RW-1:0] RMAX = RW'(DEB_CYC);

  logic [SYNC_STAGES:0] gsh_q;
  logic                 fall_seen;
  logic [RW-1:0]        run_q;
  logic                 raw_trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gsh_q <= '0;
    else        gsh_q <= {gsh_q[SYNC_STAGES-1:0], gate1};
  end

  assign fall_seen = gsh_q[SYNC_STAGES] & ~gsh_q[SYNC_STAGES-1];
  assign raw_trip  = cs_over_pos | cs_over_neg | (deep_br ? pk_ocp1_hi : pk_ocp1_nrm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (!raw_trip)  run_q <= '0;
    else if (run_q != RMAX) run_q <= run_q + 1'b1;
  end

  assert_uvlo_safe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (sr_shrink && sr_skip && !cb_slow && !cb_fast && !nzvs_req && !ocp_fault));

  assert_skip_in_shrink_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_skip |-> sr_shrink);

  assert_fast_in_slow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cb_fast |-> cb_slow);

  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_seen && !uvlo) |=> $stable({sr_shrink, sr_skip, cb_slow, cb_fast, nzvs_req}));

  assert_fault_debounced_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ocp_fault) |-> ($past(run_q, SYNC_STAGES) >= RMAX));

  assert_fault_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ocp_fault && !fault_clr && !uvlo) |=> ocp_fault);

endmodule

bind cyc_peak_supervisor cps_supervisor_chk #(
  .SYNC_STAGES(SYNC_STAGES),
  .DEB_CYC    (DEB_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .uvlo       (uvlo),
  .fault_clr  (fault_clr),
  .gate1      (gate1),
  .deep_br    (deep_br),
  .pk_ocp1_nrm(pk_ocp1_nrm),
  .pk_ocp1_hi (pk_ocp1_hi),
  .cs_over_pos(cs_over_pos),
  .cs_over_neg(cs_over_neg),
  .sr_shrink  (sr_shrink),
  .sr_skip    (sr_skip),
  .cb_slow    (cb_slow),
  .cb_fast    (cb_fast),
  .nzvs_req   (nzvs_req),
  .ocp_fault  (ocp_fault)
);

// File: tb/cyc_peak_supervisor_tb.sv
`timescale 1ns/100ps
module cyc_peak_supervisor_tb;

  localparam real CLK_PERIOD = 25.0;
  localparam int  DEB = 6;

  logic clk = 1'b0;
  logic rst_n, uvlo, fault_clr, gate1, deep_br;
  logic pk_below_shr, pk_above_shr_exit, pk_below_skp, pk_above_skp_exit;
  logic pk_ocl1_nrm, pk_ocl2_nrm, pk_ocp1_nrm, pk_ocl1_hi, pk_ocl2_hi, pk_ocp1_hi;
  logic comp_hi, cs_pk_hi, cs_over_pos, cs_over_neg;
  logic sr_shrink, sr_skip, cb_slow, cb_fast, nzvs_req, ocp_fault;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // expected model state
  logic m_shrink, m_skip, m_slow, m_fast, m_nzvs;

  always #(CLK_PERIOD/2.0) clk = ~clk;

  cyc_peak_supervisor #(.SYNC_STAGES(2), .DEB_CYC(DEB)) u_dut (
    .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .fault_clr(fault_clr),
    .gate1(gate1), .deep_br(deep_br),
    .pk_below_shr(pk_below_shr), .pk_above_shr_exit(pk_above_shr_exit),
    .pk_below_skp(pk_below_skp), .pk_above_skp_exit(pk_above_skp_exit),
    .pk_ocl1_nrm(pk_ocl1_nrm), .pk_ocl2_nrm(pk_ocl2_nrm), .pk_ocp1_nrm(pk_ocp1_nrm),
    .pk_ocl1_hi(pk_ocl1_hi), .pk_ocl2_hi(pk_ocl2_hi), .pk_ocp1_hi(pk_ocp1_hi),
    .comp_hi(comp_hi), .cs_pk_hi(cs_pk_hi),
    .cs_over_pos(cs_over_pos), .cs_over_neg(cs_over_neg),
    .sr_shrink(sr_shrink), .sr_skip(sr_skip), .cb_slow(cb_slow),
    .cb_fast(cb_fast), .nzvs_req(nzvs_req), .ocp_fault(ocp_fault)
  );

  function automatic logic [5:0] outs();
    return {ocp_fault, nzvs_req, cb_fast, cb_slow, sr_skip, sr_shrink};
  endfunction

  function automatic logic [5:0] model_vec(logic f);
    return {f, m_nzvs, m_fast, m_slow, m_skip, m_shrink};
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  // peak level in millivolt-equivalent, drives all integrated-peak comparators
  task automatic set_pk(int pk);
    pk_below_shr      = (pk < 200);
    pk_above_shr_exit = (pk > 250);
    pk_below_skp      = (pk < 75);
    pk_above_skp_exit = (pk > 150);
    pk_ocl1_nrm       = (pk > 1200);
    pk_ocl2_nrm       = (pk > 1450);
    pk_ocp1_nrm       = (pk > 1900);
    pk_ocl1_hi        = (pk > 1450);
    pk_ocl2_hi        = (pk > 1700);
    pk_ocp1_hi        = (pk > 2150);
  endtask

  task automatic model_safe();
    m_shrink = 1'b1; m_skip = 1'b1; m_slow = 1'b0; m_fast = 1'b0; m_nzvs = 1'b0;
  endtask

  // one switching cycle; checks latency (R10) and each flag
  task automatic run_cycle(int pk, logic dbr, logic ch, logic cph);
    logic [5:0] old_v;
    @(negedge clk);
    set_pk(pk); deep_br = dbr; comp_hi = ch; cs_pk_hi = cph;
    repeat (4) @(negedge clk);
    gate1 = 1'b1;
    repeat (4) @(negedge clk);
    old_v = model_vec(1'b0);
    if (pk < 200) m_shrink = 1'b1; else if (pk > 250) m_shrink = 1'b0;
    if (pk < 75)  m_skip   = 1'b1; else if (pk > 150) m_skip   = 1'b0;
    m_slow = dbr ? (pk > 1450) : (pk > 1200);
    m_fast = dbr ? (pk > 1700) : (pk > 1450);
    m_nzvs = ch & ~cph;
    gate1 = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 old flags two edges after fall", {2'b0, outs()}, {2'b0, old_v});
    @(negedge clk);
    chk("R10 new flags three edges after fall", {2'b0, outs()}, {2'b0, model_vec(1'b0)});
    chk("R2 shrink", {7'b0, sr_shrink}, {7'b0, m_shrink});
    chk("R3 skip",   {7'b0, sr_skip},   {7'b0, m_skip});
    if (dbr) chk("R5 cutbacks on high set", {6'b0, cb_fast, cb_slow}, {6'b0, m_fast, m_slow});
    else     chk("R4 cutbacks on normal set", {6'b0, cb_fast, cb_slow}, {6'b0, m_fast, m_slow});
    chk("R6 non-ZVS", {7'b0, nzvs_req}, {7'b0, m_nzvs});
  endtask

  // src 0: positive sense, 1: negative sense, 2: integrated peak level
  task automatic trip_pulse(int src, int len, int pk_lvl);
    @(negedge clk);
    case (src)
      0: cs_over_pos = 1'b1;
      1: cs_over_neg = 1'b1;
      default: set_pk(pk_lvl);
    endcase
    repeat (len) @(negedge clk);
    cs_over_pos = 1'b0; cs_over_neg = 1'b0; set_pk(100);
    repeat (10) @(negedge clk);
  endtask

  task automatic clear_fault();
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; uvlo = 1'b0; fault_clr = 1'b0; gate1 = 1'b0; deep_br = 1'b0;
    comp_hi = 1'b0; cs_pk_hi = 1'b0; cs_over_pos = 1'b0; cs_over_neg = 1'b0;
    set_pk(100);
    model_safe();
    repeat (3) @(negedge clk);
    chk("R1 reset state", {2'b0, outs()}, 8'h03);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 state after reset release", {2'b0, outs()}, 8'h03);

    // sweep of peak levels up and down, both limit sets, all COMP/sense combos
    for (int dbr = 0; dbr < 2; dbr++) begin
      for (int i = 0; i < 22; i++) begin
        int lv;
        case (i)
          0: lv = 0;     1: lv = 60;    2: lv = 100;   3: lv = 175;
          4: lv = 225;   5: lv = 300;   6: lv = 225;   7: lv = 175;
          8: lv = 100;   9: lv = 60;    10: lv = 100;  11: lv = 175;
          12: lv = 225;  13: lv = 1300; 14: lv = 1500; 15: lv = 1600;
          16: lv = 1750; 17: lv = 1850; 18: lv = 1300; 19: lv = 225;
          20: lv = 100;  default: lv = 40;
        endcase
        run_cycle(lv, dbr[0], i[0], i[1]);
        chk("R8 no fault during sweep", {7'b0, ocp_fault}, 8'h00);
      end
    end

    // R7: comparator change with no gate edge leaves flags alone
    run_cycle(1600, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    set_pk(0); comp_hi = 1'b1; cs_pk_hi = 1'b0;
    repeat (12) @(negedge clk);
    chk("R7 flags unchanged without gate edge", {2'b0, outs()}, {2'b0, model_vec(1'b0)});
    run_cycle(0, 1'b0, 1'b1, 1'b0);

    // R1: undervoltage lockout forces safe state
    run_cycle(1600, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    uvlo = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 uvlo safe state", {2'b0, outs()}, 8'h03);
    uvlo = 1'b0;
    model_safe();
    repeat (2) @(negedge clk);

    // R8/R9: debounce window for every trip source
    for (int src = 0; src < 3; src++) begin
      for (int len = 1; len <= 8; len++) begin
        trip_pulse(src, len, 2000);
        chk("R8 debounce decision", {7'b0, ocp_fault}, {7'b0, (len >= DEB)});
        if (ocp_fault) begin
          repeat (20) @(negedge clk);
          chk("R9 fault latched", {7'b0, ocp_fault}, 8'h01);
          clear_fault();
          chk("R9 fault cleared", {7'b0, ocp_fault}, 8'h00);
        end
      end
    end

    // R5: high set raises the integrated overcurrent threshold
    @(negedge clk);
    deep_br = 1'b1;
    repeat (4) @(negedge clk);
    trip_pulse(2, 10, 2000);
    chk("R5 no fault below high OCP level", {7'b0, ocp_fault}, 8'h00);
    trip_pulse(2, 10, 2200);
    chk("R5 fault above high OCP level", {7'b0, ocp_fault}, 8'h01);

    // R1: lockout also drops a latched fault
    @(negedge clk);
    uvlo = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 uvlo clears fault", {2'b0, outs()}, 8'h03);
    uvlo = 1'b0;
    deep_br = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule